// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block produces the response section that follows the end-of-data symbol of a frame on a single-wire, bit-arbitrated vehicle bus. Software writes three request bits. The block reduces them by fixed priority to one response mode and holds the winner until the response completes or is abandoned. It then drives one bus bit per slot on a bit-level symbol interface. A separate physical layer owns pulse timing and marks the end of each bit slot with a strobe and the sampled bus level.

A response starts with a single active normalization bit. That bit is suppressed if another responder has already opened the response window. It continues in one of two ways:
- Single-byte mode sends the node's own identifier byte. Several nodes may send their identifiers in the same window. The bus is wired-OR, so an active bit wins. A node that is overridden falls silent for the rest of that byte and sends its identifier again in the next slot, until the byte it receives equals its own identifier.
- Multi-byte mode streams host data through a ready/valid handshake. It can close with a CRC-8 byte.

An end-of-frame indication inside the window stops the response and leaves a failure flag set.

Top module: `ifr_tx_seq`

## Requirements
- R1: A write sets the request register to the highest-priority bit of `ctl_wdata` and clears all other bits. Priority is bit 2 (single byte) over bit 1 (multi-byte with CRC) over bit 0 (multi-byte without CRC). `ctl_rdata` returns the stored, resolved value, which has at most one bit set.
- R2: A write that arrives while the sequencer is active leaves `ctl_rdata` unchanged.
- R3: When `ctl_rdata` is zero, `eod_seen` starts nothing. `tx_drive` stays 0, `data_ready` stays 0 and no completion pulse occurs.
- R4: A response starts only on `eod_seen` with a request pending. The sequencer then waits `NB_WAIT` cycles and drives `tx_drive`=1 for one bit slot as the normalization bit. If `bus_active` rises during that wait, it drives nothing and aligns its first byte to the end of that slot.
- R5: In single-byte mode, `node_id` is sent MSB first, one bit per `bit_tick`, with 1 meaning active. When a received byte equals `node_id`, `ifr_done` pulses for one cycle and `ctl_rdata` clears.
- R6: In single-byte mode, sampling `rx_bit`=1 while sending a 0 counts as lost arbitration. `tx_drive` then stays 0 for the rest of that byte, and the identifier is sent again from its MSB in the next byte slot.
- R7: In multi-byte mode, each byte is taken when `data_ready` and `data_valid` are both high and is sent MSB first. `data_ready` is high only between bytes. The byte flagged with `data_last` ends the data.
- R8: A CRC byte follows the last data byte only in the CRC-enabled mode. It uses polynomial 0x1D with a preset of 0xFF over all data bytes, MSB first, and is sent inverted. Without CRC, `ifr_done` pulses after the last data byte.
- R9: `eof_seen` while the sequencer is active aborts it. `ifr_fail` is set and stays set, `ctl_rdata` clears and `tx_drive` goes to 0. The next accepted write clears `ifr_fail`.
- R10: A lost bit in multi-byte mode aborts the response at the end of that byte, with the same flag and clearing as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Request register write strobe |
| ctl_wdata | input | 3 | Requested mode bits |
| ctl_rdata | output | 3 | Resolved request readback |
| node_id | input | 8 | Own identifier byte |
| eod_seen | input | 1 | End-of-data symbol observed (pulse) |
| eof_seen | input | 1 | End-of-frame observed (pulse) |
| bus_active | input | 1 | Live bus level, 1 = active |
| bit_tick | input | 1 | End of a bit slot |
| rx_bit | input | 1 | Bus level sampled for the slot that ends with `bit_tick` |
| tx_drive | output | 1 | Drive active level in the current slot |
| data_in | input | 8 | Multi-byte payload byte |
| data_valid | input | 1 | Payload byte offered |
| data_last | input | 1 | Offered byte is the final one |
| data_ready | output | 1 | Sequencer takes a payload byte |
| ifr_done | output | 1 | Response completed (one-cycle pulse) |
| ifr_fail | output | 1 | Response aborted (sticky) |

## Verification
The bound checker covers the properties that hold on every cycle:
- The readback has at most one bit set.
- Writes are ignored while the sequencer is busy.
- End-of-data without a request starts nothing.
- Completion and abort both clear the request and return the sequencer to idle.
- End-of-frame always ends an active response.
- `data_ready` appears only in a multi-byte mode.
- `tx_drive` stays quiet while idle.

Some behaviour depends on the bit stream and only the bench's bus model shows it. That model is a wired-OR bus with a competing responder that also withdraws when overridden. The scenarios cover the exact bits driven per slot, retrying an identifier after a loss, suppressing the shared normalization bit, the CRC value, and the slot in which completion or failure lands.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

  localparam int REQ_W = 3;
  localparam int REQ_SINGLE = 2;
  localparam int REQ_MCRC   = 1;
  localparam int REQ_MRAW   = 0;

  typedef enum logic [1:0] {
    MODE_NONE,
    MODE_SINGLE,
    MODE_MCRC,
    MODE_MRAW
  } ifr_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_SYNC,
    S_NB,
    S_LOAD,
    S_SEND
  } ifr_state_e;

  // One byte through an MSB-first CRC register
  function automatic logic [7:0] crc8_next(input logic [7:0] crc,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ din;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/ifr_mode_reg.sv
module ifr_mode_reg
  import ifr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REQ_W-1:0] wdata,
  input  logic             accept,
  input  logic             clr,
  output logic [REQ_W-1:0] rdata,
  output ifr_mode_e        mode
);

  logic [REQ_W-1:0] req_q;
  logic [REQ_W-1:0] winner;

  // Highest set bit wins, the rest are dropped
  always_comb begin
    winner = '0;
    for (int i = REQ_W - 1; i >= 0; i--) begin
      if (wdata[i] && (winner == '0)) winner[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                req_q <= '0;
    else if (clr)           req_q <= '0;
    else if (wr && accept)  req_q <= winner;
  end

  always_comb begin
    if (req_q[REQ_SINGLE])    mode = MODE_SINGLE;
    else if (req_q[REQ_MCRC]) mode = MODE_MCRC;
    else if (req_q[REQ_MRAW]) mode = MODE_MRAW;
    else                      mode = MODE_NONE;
  end

  assign rdata = req_q;

endmodule

// File: rtl/ifr_crc8.sv
module ifr_crc8
  import ifr_pkg::*;
#(
  parameter logic [7:0] POLY = 8'h1D,
  parameter logic [7:0] SEED = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       init,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc_out
);

  logic [7:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= SEED;
    else if (upd)    crc_q <= crc8_next(crc_q, din, POLY);
  end

  assign crc_out = ~crc_q;

endmodule

// File: rtl/ifr_arb_shifter.sv
module ifr_arb_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         rx_bit,
  output logic         cur_bit,
  output logic         lost_now,
  output logic         byte_end,
  output logic [W-1:0] rx_byte
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  tx_sh;
  logic [W-1:0]  rx_sh;
  logic [CW-1:0] bcnt;
  logic          lost_q;

  assign cur_bit  = tx_sh[W-1] & ~lost_q;
  // Overridden: our bit passive while the bus reads active
  assign lost_now = lost_q | (tick & rx_bit & ~tx_sh[W-1]);
  assign byte_end = tick && (bcnt == CW'(W - 1));
  assign rx_byte  = {rx_sh[W-2:0], rx_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      bcnt   <= '0;
      lost_q <= 1'b0;
    end else if (load) begin
      tx_sh  <= load_val;
      bcnt   <= '0;
      lost_q <= 1'b0;
    end else if (tick) begin
      tx_sh <= tx_sh << 1;
      rx_sh <= rx_byte;
      if (byte_end) begin
        bcnt   <= '0;
        lost_q <= 1'b0;
      end else begin
        bcnt   <= bcnt + 1'b1;
        lost_q <= lost_now;
      end
    end
  end

endmodule

// File: rtl/ifr_tx_seq.sv
module ifr_tx_seq
  import ifr_pkg::*;
#(
  parameter int         W       = 8,
  parameter int         NB_WAIT = 4,
  parameter logic [7:0] POLY    = 8'h1D,
  parameter logic [7:0] SEED    = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [REQ_W-1:0] ctl_wdata,
  output logic [REQ_W-1:0] ctl_rdata,
  input  logic [W-1:0]     node_id,
  input  logic             eod_seen,
  input  logic             eof_seen,
  input  logic             bus_active,
  input  logic             bit_tick,
  input  logic             rx_bit,
  output logic             tx_drive,
  input  logic [W-1:0]     data_in,
  input  logic             data_valid,
  input  logic             data_last,
  output logic             data_ready,
  output logic             ifr_done,
  output logic             ifr_fail
);

  localparam int HW = $clog2(NB_WAIT + 1);

  ifr_state_e st, st_n;
  ifr_mode_e  mode;
  logic [HW-1:0] hcnt, hcnt_n;
  logic is_crc, is_crc_n;
  logic last_q, last_n;
  logic busy;
  logic shf_load;
  logic [W-1:0] shf_val;
  logic crc_init, crc_upd;
  logic done_set, fail_set;
  logic cur_bit, lost_now, byte_end;
  logic [W-1:0] rx_byte;
  logic [7:0] crc_val;
  logic tx_q, done_q, fail_q;

  assign busy = (st != S_IDLE);

  ifr_mode_reg u_mode (
    .clk   (clk),
    .rst   (rst),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .accept(!busy),
    .clr   (done_set || fail_set),
    .rdata (ctl_rdata),
    .mode  (mode)
  );

  ifr_arb_shifter #(.W(W)) u_shf (
    .clk     (clk),
    .rst     (rst),
    .load    (shf_load),
    .load_val(shf_val),
    .tick    (bit_tick && (st == S_SEND)),
    .rx_bit  (rx_bit),
    .cur_bit (cur_bit),
    .lost_now(lost_now),
    .byte_end(byte_end),
    .rx_byte (rx_byte)
  );

  ifr_crc8 #(.POLY(POLY), .SEED(SEED)) u_crc (
    .clk    (clk),
    .rst    (rst),
    .init   (crc_init),
    .upd    (crc_upd),
    .din    (data_in[7:0]),
    .crc_out(crc_val)
  );

  always_comb begin
    st_n     = st;
    hcnt_n   = hcnt;
    is_crc_n = is_crc;
    last_n   = last_q;
    shf_load = 1'b0;
    shf_val  = node_id;
    crc_init = 1'b0;
    crc_upd  = 1'b0;
    done_set = 1'b0;
    fail_set = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (eod_seen && (mode != MODE_NONE)) begin
          st_n     = S_ARM;
          hcnt_n   = '0;
          crc_init = 1'b1;
          is_crc_n = 1'b0;
        end
      end
      S_ARM: begin
        if (eof_seen) begin
          fail_set = 1'b1;
          st_n     = S_IDLE;
        end else if (bus_active) begin
          st_n = S_SYNC;
        end else if (hcnt == HW'(NB_WAIT - 1)) begin
          st_n = S_NB;
        end else begin
          hcnt_n = hcnt + 1'b1;
        end
      end
      S_SYNC, S_NB: begin
        if (eof_seen) begin
          fail_set = 1'b1;
          st_n     = S_IDLE;
        end else if (bit_tick) begin
          if (mode == MODE_SINGLE) begin
            shf_load = 1'b1;
            st_n     = S_SEND;
          end else begin
            st_n = S_LOAD;
          end
        end
      end
      S_LOAD: begin
        if (eof_seen) begin
          fail_set = 1'b1;
          st_n     = S_IDLE;
        end else if (data_valid) begin
          shf_load = 1'b1;
          shf_val  = data_in;
          crc_upd  = 1'b1;
          last_n   = data_last;
          st_n     = S_SEND;
        end
      end
      S_SEND: begin
        if (eof_seen) begin
          fail_set = 1'b1;
          st_n     = S_IDLE;
        end else if (byte_end) begin
          if (mode == MODE_SINGLE) begin
            if (rx_byte == node_id) begin
              done_set = 1'b1;
              st_n     = S_IDLE;
            end else begin
              shf_load = 1'b1;
            end
          end else if (lost_now) begin
            fail_set = 1'b1;
            st_n     = S_IDLE;
          end else if (is_crc) begin
            done_set = 1'b1;
            st_n     = S_IDLE;
          end else if (last_q) begin
            if (mode == MODE_MCRC) begin
              shf_load = 1'b1;
              shf_val  = W'(crc_val);
              is_crc_n = 1'b1;
            end else begin
              done_set = 1'b1;
              st_n     = S_IDLE;
            end
          end else begin
            st_n = S_LOAD;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      hcnt   <= '0;
      is_crc <= 1'b0;
      last_q <= 1'b0;
      tx_q   <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st     <= st_n;
      hcnt   <= hcnt_n;
      is_crc <= is_crc_n;
      last_q <= last_n;
      tx_q   <= (st == S_NB) || ((st == S_SEND) && cur_bit);
      done_q <= done_set;
      if (fail_set)              fail_q <= 1'b1;
      else if (ctl_wr && !busy)  fail_q <= 1'b0;
    end
  end

  assign tx_drive   = tx_q;
  assign data_ready = (st == S_LOAD);
  assign ifr_done   = done_q;
  assign ifr_fail   = fail_q;

endmodule

// File: rtl/ifr_tx_chk.sv
module ifr_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [2:0] ctl_rdata,
  input logic       eod_seen,
  input logic       eof_seen,
  input logic       tx_drive,
  input logic       data_ready,
  input logic       ifr_done,
  input logic       ifr_fail,
  input logic       busy
);

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl_rdata));

  a_r2_busy_write: assert property (@(posedge clk) disable iff (rst)
    busy && ctl_wr |=> ifr_done || $rose(ifr_fail) || $stable(ctl_rdata));

  a_r3_no_req_idle: assert property (@(posedge clk) disable iff (rst)
    !busy && eod_seen && (ctl_rdata == 3'b000) |=> !busy);

  a_r4_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> !tx_drive);

  a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
    ifr_done |-> (ctl_rdata == 3'b000) && !busy);

  a_r7_ready_multi: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> (ctl_rdata[1] || ctl_rdata[0]));

  a_r9_eof_ends: assert property (@(posedge clk) disable iff (rst)
    busy && eof_seen |=> !busy);

  a_r9_fail_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(ifr_fail) |-> (ctl_rdata == 3'b000) && !busy && !ifr_done);

endmodule

bind ifr_tx_seq ifr_tx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_wr    (ctl_wr),
  .ctl_rdata (ctl_rdata),
  .eod_seen  (eod_seen),
  .eof_seen  (eof_seen),
  .tx_drive  (tx_drive),
  .data_ready(data_ready),
  .ifr_done  (ifr_done),
  .ifr_fail  (ifr_fail),
  .busy      (busy)
);

// File: tb/ifr_tx_seq_bench.sv
`timescale 1ns/1ps
module ifr_tx_seq_bench;

  localparam int NB_WAIT = 4;
  localparam int TICK    = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic [2:0] ctl_rdata;
  logic [7:0] node_id = '0;
  logic       eod_seen = 1'b0, eof_seen = 1'b0, bus_active = 1'b0;
  logic       bit_tick = 1'b0, rx_bit = 1'b0;
  logic       tx_drive;
  logic [7:0] data_in = '0;
  logic       data_valid = 1'b0, data_last = 1'b0;
  logic       data_ready, ifr_done, ifr_fail;

  int errors = 0;
  int checks = 0;

  logic [7:0] mbuf [0:7];
  int         mlen = 0;
  logic       mdata_en = 1'b0;
  int         midx = 0;
  logic       hs_pend = 1'b0;

  always #2 clk = ~clk;

  ifr_tx_seq #(.NB_WAIT(NB_WAIT)) u_ifr_tx_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .node_id(node_id), .eod_seen(eod_seen),
    .eof_seen(eof_seen), .bus_active(bus_active), .bit_tick(bit_tick),
    .rx_bit(rx_bit), .tx_drive(tx_drive), .data_in(data_in),
    .data_valid(data_valid), .data_last(data_last), .data_ready(data_ready),
    .ifr_done(ifr_done), .ifr_fail(ifr_fail)
  );

  // Payload source: presents mbuf in order, advances after each handshake
  always @(negedge clk) begin
    if (!mdata_en) begin
      midx    = 0;
      hs_pend = 1'b0;
    end else if (hs_pend) begin
      midx = midx + 1;
    end
    data_valid = mdata_en && (midx < mlen);
    data_in    = mbuf[midx[2:0]];
    data_last  = (midx == mlen - 1);
    hs_pend    = data_ready && data_valid;
  end

  function automatic logic [2:0] prio(input logic [2:0] v);
    if (v[2]) return 3'b100;
    if (v[1]) return 3'b010;
    if (v[0]) return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c;
    c = 8'hFF;
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[7] ^ mbuf[k][b];
        c  = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h1D;
      end
    end
    return ~c;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [2:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse_eod();
    @(negedge clk); eod_seen = 1'b1;
    @(negedge clk); eod_seen = 1'b0;
  endtask

  task automatic tick(input logic lvl);
    rx_bit = lvl; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  // Normalization slot; with sync another node opens the window
  task automatic do_nb(input logic sync);
    pulse_eod();
    if (sync) begin
      bus_active = 1'b1;
      repeat (NB_WAIT + 3) @(negedge clk);
      chk(tx_drive == 1'b0, "R4", "no own normalization bit", tx_drive, 0);
      tick(1'b1);
      bus_active = 1'b0;
    end else begin
      repeat (NB_WAIT + 3) @(negedge clk);
      chk(tx_drive == 1'b1, "R4", "normalization bit driven", tx_drive, 1);
      tick(1'b1);
    end
  endtask

  // One byte slot on a wired-OR bus with an optional competitor
  task automatic do_slot(input logic comp_on, input logic [7:0] comp,
                         input logic [7:0] refb, input string req,
                         output logic [7:0] rxb, output logic dn,
                         output logic fl);
    logic lost_us, lost_c, exp, cb, bus;
    lost_us = 1'b0; lost_c = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      repeat (TICK - 1) @(negedge clk);
      exp = !lost_us && refb[i];
      chk(tx_drive == exp, req, $sformatf("drive bit %0d", i), tx_drive, exp);
      cb  = comp_on && !lost_c && comp[i];
      bus = tx_drive | cb;
      if (!refb[i] && bus) lost_us = 1'b1;
      if (comp_on && !comp[i] && bus) lost_c = 1'b1;
      rxb[i] = bus;
      tick(bus);
    end
    dn = ifr_done;
    fl = ifr_fail;
  endtask

  task automatic run_single(input logic [7:0] id, input logic comp_on,
                            input logic [7:0] comp, input logic sync);
    logic [7:0] rx;
    logic dn, fl, c_act;
    int slots, exp_slots;
    node_id = id;
    write_ctl(3'b100);
    do_nb(sync);
    write_ctl(3'b011);
    chk(ctl_rdata == 3'b100, "R2", "write ignored while active", ctl_rdata, 3'b100);
    c_act = comp_on;
    slots = 0;
    exp_slots = (comp_on && comp > id) ? 2 : 1;
    for (int s = 0; s < 4; s++) begin
      do_slot(c_act, comp, id, (s == 0) ? "R5" : "R6", rx, dn, fl);
      slots++;
      chk(dn == (rx == id), "R6", "done only on own id received", dn, rx == id);
      if (rx == id) break;
      c_act = c_act && (rx != comp);
    end
    chk(slots == exp_slots, "R6", "slots to completion", slots, exp_slots);
    chk(ctl_rdata == 3'b000, "R5", "request cleared on done", ctl_rdata, 0);
    @(negedge clk);
    chk(ifr_done == 1'b0, "R5", "done is one cycle", ifr_done, 0);
  endtask

  task automatic run_multi(input logic crc_on, input int n);
    logic [7:0] rx, exp_crc;
    logic dn, fl;
    node_id = 8'h00;
    mlen = n;
    mdata_en = 1'b1;
    write_ctl(crc_on ? 3'b010 : 3'b001);
    do_nb(1'b0);
    for (int k = 0; k < n; k++) begin
      do_slot(1'b0, 8'h00, mbuf[k], "R7", rx, dn, fl);
      chk(dn == (!crc_on && k == n - 1), "R8", "done after data", dn,
          !crc_on && k == n - 1);
    end
    if (crc_on) begin
      exp_crc = ref_crc(n);
      do_slot(1'b0, 8'h00, exp_crc, "R8", rx, dn, fl);
      chk(dn == 1'b1, "R8", "done after CRC byte", dn, 1);
    end
    chk(midx == n, "R7", "bytes consumed", midx, n);
    chk(ctl_rdata == 3'b000, "R8", "request cleared", ctl_rdata, 0);
    mdata_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic dn, fl, bad;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctl_rdata == 0 && tx_drive == 0 && ifr_done == 0 && ifr_fail == 0,
        "R1", "reset state", {ctl_rdata, tx_drive, ifr_done, ifr_fail}, 0);

    // R1 directed and random priority resolution
    write_ctl(3'b111); chk(ctl_rdata == 3'b100, "R1", "111", ctl_rdata, 3'b100);
    write_ctl(3'b011); chk(ctl_rdata == 3'b010, "R1", "011", ctl_rdata, 3'b010);
    write_ctl(3'b001); chk(ctl_rdata == 3'b001, "R1", "001", ctl_rdata, 3'b001);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] v;
      v = 3'($urandom);
      write_ctl(v);
      chk(ctl_rdata == prio(v), "R1", "random write", ctl_rdata, prio(v));
    end

    // R3: no request, end-of-data starts nothing
    write_ctl(3'b000);
    pulse_eod();
    bad = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_drive || data_ready || ifr_done) bad = 1'b1;
    end
    chk(!bad, "R3", "quiet without request", bad, 0);

    // R4: request without end-of-data stays quiet
    write_ctl(3'b100);
    bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_drive) bad = 1'b1;
    end
    chk(!bad, "R4", "no start before end-of-data", bad, 0);
    write_ctl(3'b000);

    // R5/R6 directed
    run_single(8'h5A, 1'b0, 8'h00, 1'b0);
    run_single(8'h31, 1'b1, 8'hC4, 1'b1);
    run_single(8'hE0, 1'b1, 8'h2F, 1'b0);
    run_single(8'h44, 1'b1, 8'h44, 1'b1);
    for (int r = 0; r < 6; r++) begin
      run_single(8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    end

    // R7/R8 directed and random
    mbuf[0] = 8'h12; mbuf[1] = 8'h80; mbuf[2] = 8'hFF;
    run_multi(1'b1, 3);
    run_multi(1'b0, 1);
    for (int r = 0; r < 4; r++) begin
      int n;
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < 8; k++) mbuf[k] = 8'($urandom);
      run_multi(1'($urandom), n);
    end

    // R9: end-of-frame before own id is seen
    node_id = 8'h10;
    write_ctl(3'b100);
    do_nb(1'b0);
    do_slot(1'b1, 8'hF0, 8'h10, "R6", rx, dn, fl);
    chk(rx == 8'hF0 && !dn, "R6", "lost slot one", rx, 8'hF0);
    do_slot(1'b1, 8'hF0, 8'h10, "R6", rx, dn, fl);
    chk(!dn, "R6", "lost slot two", dn, 0);
    @(negedge clk); eof_seen = 1'b1;
    @(negedge clk); eof_seen = 1'b0;
    chk(ifr_fail == 1'b1, "R9", "fail flag", ifr_fail, 1);
    chk(ctl_rdata == 3'b000, "R9", "request cleared", ctl_rdata, 0);
    repeat (2) @(negedge clk);
    chk(tx_drive == 1'b0 && ifr_fail == 1'b1, "R9", "released, flag held",
        {tx_drive, ifr_fail}, 1);
    write_ctl(3'b001);
    chk(ifr_fail == 1'b0 && ctl_rdata == 3'b001, "R9", "write clears flag",
        {ifr_fail, ctl_rdata}, 3'b001);

    // R10: overridden during multi-byte data
    mbuf[0] = 8'h21; mlen = 2; mdata_en = 1'b1;
    do_nb(1'b0);
    do_slot(1'b1, 8'h80, 8'h21, "R10", rx, dn, fl);
    chk(fl == 1'b1 && dn == 1'b0, "R10", "abort on loss", {fl, dn}, 2);
    chk(ctl_rdata == 3'b000, "R10", "request cleared", ctl_rdata, 0);
    mdata_en = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule